// File: doc/BRIEF.md
# Dual-Line Serial Flash Command Front End

This block is the slave-side command front end of a serial flash running in a two-line mode. Every serial clock that chip select is low, it takes one bit pair from the two data lines. The pairs carry the operation code, then the 24-bit address, then the data. It decodes the operation code and maps several alias codes onto the same operation. For reads it inserts a configurable run of dummy clocks. It then streams bytes from a memory-side port, accepts bytes for programming, or returns a short identification string. The block is clocked by the serial clock itself. Each rising edge with chip select low consumes one pair.

The memory-side port is a combinational lookup. The block presents `mem_addr`, and `mem_rdata` must reflect the byte at that address in the same cycle. `mem_rd` marks the cycles in which a byte is taken from it. `mem_wr` marks each fully received program byte. `prog_commit` tells the array side whether a program stream ended cleanly. `short_gap` tells the host side which minimum chip-select-high time applies before the next command.

Top module: `dual_flash_front`

## Requirements
- R1: The operation code takes 4 clocks and the address takes 12 clocks. Both are sent most significant pair first, and in each pair `dq_in[1]` is the higher bit.
- R2: Codes BBh, 3Bh and 0Bh start a fast read. After the address and the dummy clocks, one byte is output per 4 clocks, starting at the received address and incrementing. Each byte goes most significant pair first on `dq_out`, with `dq_out[1]` as the higher bit.
- R3: Codes D2h, A2h and 02h start a page program. Every 4 data pairs after the address produce one `mem_wr` pulse. The pulse carries the assembled byte and the address, and the address increments per byte.
- R4: The number of dummy clocks equals `dummy_cfg` for values 1 to 15. A value of 0 selects 8 clocks.
- R5: Code AFh returns exactly 3 identification bytes, most significant byte of `ID_VALUE` first. After those bytes the lines are released until chip select rises.
- R6: Every other code is ignored: no output enable, no `mem_rd` and no `mem_wr` until chip select rises. Examples are the plain read 03h, the quad commands 6Bh, EBh, 32h and 12h, and the single-line identification 9Fh.
- R7: `dq_oe` is high only while read or identification bytes are being shifted out. It is low during the operation-code, address and dummy clocks.
- R8: Raising chip select at any point aborts the command, and the next command is decoded from its operation code.
- R9: `prog_commit` pulses in the first chip-select-high cycle only when a program command ended after at least one whole byte and exactly on a byte boundary.
- R10: `short_gap` is updated at each rise of chip select. It becomes 1 if a fast read had delivered at least one whole byte, and 0 otherwise. It holds its value between rises.
- R11: After reset, `dq_oe`, `mem_rd`, `mem_wr`, `prog_commit` and `short_gap` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; one bit pair per rising edge while selected |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| dq_in | input | 2 | Bit pair sampled from the two data lines |
| dummy_cfg | input | 4 | Dummy clock count field from the volatile configuration |
| dq_out | output | 2 | Bit pair driven on the data lines |
| dq_oe | output | 1 | Output enable for both data lines |
| mem_addr | output | ADDR_W | Current array address |
| mem_rd | output | 1 | Byte taken from `mem_rdata` this cycle |
| mem_rdata | input | 8 | Array byte at `mem_addr` |
| mem_wr | output | 1 | Program byte write strobe |
| mem_wdata | output | 8 | Program byte |
| prog_commit | output | 1 | Program stream ended cleanly |
| short_gap | output | 1 | Short chip-select-high minimum applies |

## Verification
Several properties are checked on every cycle by the assertions:
- the address steps by one after each fetch and after each program byte;
- read and write strobes never coincide;
- the output enable only rises right after the last dummy clock or the operation code;
- a commit pulse appears only in the first chip-select-high cycle;
- `short_gap` changes only at a chip-select rise.

Other behaviour needs a full command, so only the bench's scenarios show it:
- that each alias code reaches the right operation;
- that the dummy count lines up the first data byte for each configuration value;
- that identification stops after three bytes;
- that rejected codes stay silent;
- that an aborted command leaves the decoder ready for a fresh operation code.

// File: rtl/dfl_pkg.sv
package dfl_pkg;
  localparam int DUMMY_W = 4;

  typedef enum logic [2:0] {
    PH_OPC, PH_ADDR, PH_DUMMY, PH_RDATA, PH_PDATA, PH_ID, PH_IDLE
  } phase_e;

  typedef enum logic [1:0] {OPK_NONE, OPK_READ, OPK_PROG, OPK_ID} opkind_e;

  // dummy field 0 means the default of 8 clocks
  function automatic logic [DUMMY_W:0] dummy_len(input logic [DUMMY_W-1:0] f);
    return (f == '0) ? (DUMMY_W+1)'(8) : {1'b0, f};
  endfunction
endpackage

// File: rtl/dfl_opdec.sv
module dfl_opdec #(
  parameter logic [7:0] ID_OP = 8'hAF
) (
  input  logic [7:0]       opcode,
  output dfl_pkg::opkind_e kind
);
  import dfl_pkg::*;
  localparam int N_ALIAS = 3;
  localparam logic [7:0] RD_OPS [N_ALIAS] = '{8'hBB, 8'h3B, 8'h0B};
  localparam logic [7:0] PG_OPS [N_ALIAS] = '{8'hD2, 8'hA2, 8'h02};

  always_comb begin
    kind = OPK_NONE;
    for (int i = 0; i < N_ALIAS; i++) begin
      if (opcode == RD_OPS[i]) kind = OPK_READ;
      if (opcode == PG_OPS[i]) kind = OPK_PROG;
    end
    if (opcode == ID_OP) kind = OPK_ID;
  end
endmodule

// File: rtl/dfl_rxshift.sv
module dfl_rxshift #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [1:0]   din,
  output logic [W-1:0] word_nxt
);
  logic [W-1:0] sr_q;

  assign word_nxt = {sr_q[W-3:0], din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  sr_q <= '0;
    else if (en) sr_q <= word_nxt;
  end
endmodule

// File: rtl/dfl_txshift.sv
module dfl_txshift (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] load_byte,
  input  logic       shift,
  output logic [1:0] pair
);
  logic [7:0] sr_q;

  assign pair = sr_q[7:6];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr_q <= '0;
    else if (load)  sr_q <= load_byte;
    else if (shift) sr_q <= {sr_q[5:0], 2'b00};
  end
endmodule

// File: rtl/dual_flash_front.sv
module dual_flash_front #(
  parameter int               ADDR_W   = 24,
  parameter int               ID_LEN   = 3,
  parameter logic [ID_LEN*8-1:0] ID_VALUE = 24'h5E21C3,
  parameter logic [7:0]       ID_OP    = 8'hAF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic [1:0]        dq_in,
  input  logic [3:0]        dummy_cfg,
  output logic [1:0]        dq_out,
  output logic              dq_oe,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_rd,
  input  logic [7:0]        mem_rdata,
  output logic              mem_wr,
  output logic [7:0]        mem_wdata,
  output logic              prog_commit,
  output logic              short_gap
);
  import dfl_pkg::*;

  localparam int ADDR_PAIRS = ADDR_W / 2;
  localparam int CNT_MAX    = (ADDR_PAIRS > (1 << DUMMY_W)) ? ADDR_PAIRS : (1 << DUMMY_W);
  localparam int CNT_W      = $clog2(CNT_MAX + 1);
  localparam int IDX_W      = $clog2(ID_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_BYTE_END = CNT_W'(3);
  localparam logic [CNT_W-1:0] CNT_ADDR_END = CNT_W'(ADDR_PAIRS - 1);
  localparam logic [IDX_W-1:0] IDX_LAST     = IDX_W'(ID_LEN - 1);

  function automatic logic [7:0] id_pick(input logic [IDX_W-1:0] i);
    return ID_VALUE[(ID_LEN - 1 - int'(i)) * 8 +: 8];
  endfunction

  phase_e             phase_q;
  opkind_e            kind_q, dec_kind;
  logic [CNT_W-1:0]   cnt_q;
  logic [ADDR_W-1:0]  addr_q;
  logic [IDX_W-1:0]   idx_q, id_next_idx;
  logic               any_byte_q, cs_q, short_q;
  logic [ADDR_W-1:0]  word_nxt;
  logic [CNT_W-1:0]   dummy_end;

  // named internal events
  logic active, cs_rise, opc_done, addr_done, dummy_done;
  logic rbyte_done, pbyte_done, idbyte_done, fetch, id_load, tx_load, tx_shift;
  logic [7:0] tx_byte;

  dfl_rxshift #(.W(ADDR_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .en(active), .din(dq_in), .word_nxt(word_nxt)
  );

  dfl_opdec #(.ID_OP(ID_OP)) u_dec (.opcode(word_nxt[7:0]), .kind(dec_kind));

  assign dummy_end   = CNT_W'(dummy_len(dummy_cfg) - 1'b1);
  assign active      = !cs_n;
  assign cs_rise     = cs_n && !cs_q;
  assign opc_done    = active && phase_q == PH_OPC   && cnt_q == CNT_BYTE_END;
  assign addr_done   = active && phase_q == PH_ADDR  && cnt_q == CNT_ADDR_END;
  assign dummy_done  = active && phase_q == PH_DUMMY && cnt_q == dummy_end;
  assign rbyte_done  = active && phase_q == PH_RDATA && cnt_q == CNT_BYTE_END;
  assign pbyte_done  = active && phase_q == PH_PDATA && cnt_q == CNT_BYTE_END;
  assign idbyte_done = active && phase_q == PH_ID    && cnt_q == CNT_BYTE_END;
  assign fetch       = dummy_done || rbyte_done;
  assign id_load     = (opc_done && dec_kind == OPK_ID) || (idbyte_done && idx_q != IDX_LAST);
  assign id_next_idx = opc_done ? '0 : idx_q + 1'b1;
  assign tx_load     = fetch || id_load;
  assign tx_byte     = fetch ? mem_rdata : id_pick(id_next_idx);
  assign tx_shift    = active && (phase_q == PH_RDATA || phase_q == PH_ID);

  dfl_txshift u_tx (
    .clk(clk), .rst_n(rst_n), .load(tx_load), .load_byte(tx_byte),
    .shift(tx_shift), .pair(dq_out)
  );

  assign dq_oe       = tx_shift;
  assign mem_addr    = addr_q;
  assign mem_rd      = fetch;
  assign mem_wr      = pbyte_done;
  assign mem_wdata   = word_nxt[7:0];
  assign prog_commit = cs_rise && phase_q == PH_PDATA && cnt_q == '0 && any_byte_q;
  assign short_gap   = short_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_OPC;
      kind_q     <= OPK_NONE;
      cnt_q      <= '0;
      addr_q     <= '0;
      idx_q      <= '0;
      any_byte_q <= 1'b0;
      cs_q       <= 1'b1;
      short_q    <= 1'b0;
    end else begin
      cs_q <= cs_n;
      if (cs_rise) short_q <= (phase_q == PH_RDATA) && any_byte_q;
      if (cs_n) begin
        phase_q    <= PH_OPC;
        cnt_q      <= '0;
        any_byte_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        unique case (phase_q)
          PH_OPC: if (opc_done) begin
            cnt_q  <= '0;
            kind_q <= dec_kind;
            idx_q  <= '0;
            unique case (dec_kind)
              OPK_READ, OPK_PROG: phase_q <= PH_ADDR;
              OPK_ID:             phase_q <= PH_ID;
              default:            phase_q <= PH_IDLE;
            endcase
          end
          PH_ADDR: if (addr_done) begin
            cnt_q   <= '0;
            addr_q  <= word_nxt;
            phase_q <= (kind_q == OPK_READ) ? PH_DUMMY : PH_PDATA;
          end
          PH_DUMMY: if (dummy_done) begin
            cnt_q   <= '0;
            addr_q  <= addr_q + 1'b1;
            phase_q <= PH_RDATA;
          end
          PH_RDATA, PH_PDATA: if (rbyte_done || pbyte_done) begin
            cnt_q      <= '0;
            addr_q     <= addr_q + 1'b1;
            any_byte_q <= 1'b1;
          end
          PH_ID: if (idbyte_done) begin
            cnt_q <= '0;
            if (idx_q == IDX_LAST) phase_q <= PH_IDLE;
            else                   idx_q   <= idx_q + 1'b1;
          end
          default: cnt_q <= cnt_q;
        endcase
      end
    end
  end

  AST_FETCH_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> mem_addr == $past(mem_addr) + ADDR_W'(1));                     // R2
  AST_WRITE_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> mem_addr == $past(mem_addr) + ADDR_W'(1));                     // R3
  AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));                                                     // R3
  AST_OE_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> ($past(dummy_done) || $past(opc_done)));                 // R7
  AST_COMMIT_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    prog_commit |-> (cs_n && !$past(cs_n)));                                  // R9
  AST_GAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_rise |=> $stable(short_gap));                                         // R10
endmodule

// File: tb/dual_flash_front_bench.sv
module dual_flash_front_bench;
  localparam logic [23:0] ID_VAL = 24'h5E21C3;

  logic        clk = 0, rst_n = 0, cs_n = 1;
  logic [1:0]  dq_in = 0;
  logic [3:0]  dummy_cfg = 0;
  logic [1:0]  dq_out;
  logic        dq_oe, mem_rd, mem_wr, prog_commit, short_gap;
  logic [23:0] mem_addr;
  logic [7:0]  mem_rdata, mem_wdata;

  int n_chk = 0, n_fail = 0;
  int rd_n = 0, wr_n = 0;
  logic [23:0] wr_addr [64];
  logic [7:0]  wr_data [64];
  logic oe_seen = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  function automatic logic [7:0] mem_byte(input logic [23:0] a);
    return (a[7:0] ^ 8'hA5) + a[15:8] + {a[23:20], 4'h0};
  endfunction
  assign mem_rdata = mem_byte(mem_addr);

  always @(posedge clk) begin
    if (mem_rd) rd_n <= rd_n + 1;
    if (mem_wr) begin
      wr_addr[wr_n % 64] <= mem_addr;
      wr_data[wr_n % 64] <= mem_wdata;
      wr_n <= wr_n + 1;
    end
  end

  dual_flash_front #(.ID_VALUE(ID_VAL)) u_dual_flash_front (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .dq_in(dq_in), .dummy_cfg(dummy_cfg),
    .dq_out(dq_out), .dq_oe(dq_oe), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_rdata(mem_rdata), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
    .prog_commit(prog_commit), .short_gap(short_gap)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_pair(input logic [1:0] p);
    @(negedge clk);
    cs_n = 0; dq_in = p;
    #1 oe_seen = oe_seen | dq_oe;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 3; i >= 0; i--) send_pair(b[2*i +: 2]);
  endtask

  task automatic send_addr(input logic [23:0] a);
    for (int i = 11; i >= 0; i--) send_pair(a[2*i +: 2]);
  endtask

  task automatic recv_byte(output logic [7:0] b, output bit oe_all);
    b = 0; oe_all = 1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      cs_n = 0;
      oe_all &= dq_oe;
      b = {b[5:0], dq_out};
    end
  endtask

  task automatic end_cmd(output bit commit);
    @(negedge clk);
    cs_n = 1;
    #1 commit = prog_commit;
    @(negedge clk);
  endtask

  task automatic t_reset;
    check(dq_oe == 0 && mem_rd == 0 && mem_wr == 0, "R11 outputs idle", dq_oe, 0);
    check(prog_commit == 0 && short_gap == 0, "R11 flags clear", short_gap, 0);
  endtask

  task automatic t_read(input logic [7:0] op, input logic [23:0] a, input logic [3:0] cfg, input int nb);
    int dl; logic [7:0] b; bit oe_all, cm;
    dummy_cfg = cfg;
    dl = (cfg == 0) ? 8 : int'(cfg);
    oe_seen = 0;
    send_byte(op); send_addr(a);
    for (int i = 0; i < dl; i++) send_pair(2'b11);
    check(!oe_seen, "R7 no drive in opcode/address/dummy", oe_seen, 0);
    for (int i = 0; i < nb; i++) begin
      recv_byte(b, oe_all);
      check(b == mem_byte(a + 24'(i)), "R2 R4 R1 read byte", b, mem_byte(a + 24'(i)));
      check(oe_all, "R7 drive during read data", oe_all, 1);
    end
    end_cmd(cm);
    check(!cm, "R9 no commit after read", cm, 0);
    check(short_gap == 1, "R10 short gap after read", short_gap, 1);
  endtask

  task automatic t_prog(input logic [7:0] op, input logic [23:0] a, input int nb, input int extra);
    int w0; bit cm; logic [7:0] d;
    w0 = wr_n;
    oe_seen = 0;
    send_byte(op); send_addr(a);
    for (int i = 0; i < nb; i++) send_byte(8'h3C + 8'(i * 41));
    for (int i = 0; i < extra; i++) send_pair(2'b01);
    end_cmd(cm);
    check(wr_n - w0 == nb, "R3 write count", wr_n - w0, nb);
    for (int i = 0; i < nb; i++) begin
      d = 8'h3C + 8'(i * 41);
      check(wr_addr[(w0 + i) % 64] == a + 24'(i), "R3 write address", wr_addr[(w0 + i) % 64], a + 24'(i));
      check(wr_data[(w0 + i) % 64] == d, "R3 write data", wr_data[(w0 + i) % 64], d);
    end
    check(cm == (extra == 0 && nb > 0), "R9 commit on byte boundary", cm, (extra == 0 && nb > 0));
    check(!oe_seen, "R7 no drive during program", oe_seen, 0);
    check(short_gap == 0, "R10 no short gap after program", short_gap, 0);
  endtask

  task automatic t_id;
    logic [7:0] b; bit oe_all, cm; int r0;
    r0 = rd_n;
    send_byte(8'hAF);
    for (int i = 0; i < 3; i++) begin
      recv_byte(b, oe_all);
      check(b == ID_VAL[(2 - i) * 8 +: 8] && oe_all, "R5 id byte", b, ID_VAL[(2 - i) * 8 +: 8]);
    end
    recv_byte(b, oe_all);
    check(dq_oe == 0, "R5 released after 3 id bytes", dq_oe, 0);
    end_cmd(cm);
    check(rd_n == r0, "R5 id does not touch array", rd_n - r0, 0);
    check(short_gap == 0, "R10 id is not a fast read", short_gap, 0);
  endtask

  task automatic t_reject(input logic [7:0] op);
    int r0, w0; bit cm;
    r0 = rd_n; w0 = wr_n; oe_seen = 0;
    send_byte(op);
    for (int i = 0; i < 24; i++) send_pair(2'(i));
    end_cmd(cm);
    check(!oe_seen && rd_n == r0 && wr_n == w0 && !cm, "R6 rejected opcode silent", op, 0);
    check(short_gap == 0, "R10 cleared by rejected command", short_gap, 1'b0);
  endtask

  task automatic t_abort;
    bit cm;
    send_byte(8'h0B);
    for (int i = 0; i < 6; i++) send_pair(2'b10);
    end_cmd(cm);
    check(short_gap == 0, "R8 abort in address gives long gap", short_gap, 0);
    t_read(8'h3B, 24'h00_40_10, 4'd2, 2);
    send_pair(2'b10); send_pair(2'b11);
    end_cmd(cm);
    t_id;
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_read(8'hBB, 24'h12_34_56, 4'd0, 3);
    t_read(8'h3B, 24'hAB_CD_FE, 4'd3, 4);
    t_read(8'h0B, 24'h00_00_FF, 4'd15, 2);
    t_read(8'hBB, 24'hFF_FF_FE, 4'd1, 3);
    t_prog(8'hD2, 24'h01_02_03, 3, 0);
    t_prog(8'hA2, 24'h7F_00_FE, 2, 0);
    t_prog(8'h02, 24'h00_10_00, 2, 2);
    t_prog(8'hD2, 24'h00_20_00, 0, 0);
    t_id;
    t_read(8'h0B, 24'h00_00_01, 4'd4, 1);
    t_reject(8'h03);
    t_reject(8'h6B);
    t_reject(8'hEB);
    t_reject(8'h32);
    t_reject(8'h12);
    t_reject(8'h9F);
    t_abort;
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule